// File: doc/BRIEF.md
# Multiplexed-Address Burst Read Responder

This block is the device side of a synchronous burst read on a shared 16-bit address/data bus. The host places the address on the bus in up to two phases while it holds the address strobe low. When the strobe is low on two consecutive rising edges, the first edge carries the upper address bits and the second carries bits 15:0. When the strobe is low on only one edge, that edge carries bits 15:0 and the upper bits latched last time are used again. The last strobe edge of an access starts a programmable latency. After the latency the block returns one 16-bit word per clock from an internal word array, and the word address increments each cycle.

A WAIT handshake tells the host which cycles carry valid data. Two configuration inputs set its behaviour. One selects the active level. The other selects whether WAIT lines up with the data cycle it describes or leads it by one clock. In wrap mode the burst stays inside its aligned 16-word line. In linear mode the burst runs on past the line end, and each line crossing costs one empty WAIT cycle. The data and WAIT pins are modelled as values with separate drive-enable flags. Every output comes from a register.

Top module: `mabr_responder`

## Requirements
- R1: When the address strobe is sampled low with select low on two consecutive rising edges, the first edge supplies the upper address bits (bus bits 3:0; the remaining bus bits are ignored) and the second edge supplies bits 15:0. The full word address is {upper, lower}.
- R2: When the strobe is sampled low on a single edge, that edge supplies bits 15:0, and the upper bits latched most recently are reused.
- R3: Take E as the last strobe-low edge of an access and L as the latency input, where values 0 and 1 act as 2. The first word is on the bus in the cycle that follows edge E+L, and the data drive flag stays low before that cycle.
- R4: After the first word, one word is returned per cycle at consecutive addresses. The array word at index k = {addr[17:16], addr[5:0]} holds (k*40503 + 4660) mod 65536.
- R5: With linear mode off, the address increments only in its low 4 bits, so the burst wraps inside its aligned 16-word line with no empty cycle.
- R6: With linear mode on, a word whose low 4 address bits are 15 is followed by exactly one cycle with no data and WAIT asserted. The burst then continues at the next address, and the carry propagates into the upper bits.
- R7: The WAIT pin is high when asserted if wait_high is 1, and low when asserted if wait_high is 0. Outside a burst it rests at the deasserted level.
- R8: With wait_early = 0, WAIT is asserted in exactly the burst cycles that carry no valid word. With wait_early = 1, WAIT in each cycle shows whether the following cycle carries no valid word.
- R9: wait_oe is high in a cycle exactly when select and output-enable were both low at the edge that starts that cycle. bus_oe additionally requires that a burst has passed its latency. A burst continues while output-enable is high.
- R10: A new strobe-low edge aborts a burst in progress and starts a new access.
- R11: Select sampled high ends the burst and clears both drive flags. When select returns low without a strobe, no data is driven and WAIT stays deasserted.
- R12: Synchronous reset clears both drive flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Device select, active low |
| rd_n | input | 1 | Output enable, active low |
| astb_n | input | 1 | Address strobe, active low |
| bus_in | input | 16 | Bus value driven by the host |
| cfg_lat | input | 3 | Latency count (2 to 7) |
| cfg_wait_high | input | 1 | WAIT asserted level: 1 high, 0 low |
| cfg_wait_early | input | 1 | WAIT leads data by one cycle when 1 |
| cfg_linear | input | 1 | Linear burst across lines when 1, wrap when 0 |
| bus_out | output | 16 | Data word driven toward the host |
| bus_oe | output | 1 | Drive enable for bus_out |
| wait_out | output | 1 | WAIT pin value |
| wait_oe | output | 1 | Drive enable for wait_out |

## Verification
A wrong latch or word address shows up as a wrong bus_out value on the very first data cycle, L clocks after the last strobe edge. A slip in the latency count or the line-gap flag shifts every later WAIT edge and data word by one cycle, and the mismatch appears within one cycle of the fault. The sweep covers every latency value, both WAIT polarities and timings, both burst modes, and both one- and two-phase addressing. The start addresses sit just below a line end, so each run crosses a line inside its observed window.

// File: rtl/mabr_pkg.sv
package mabr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAT    = 2'd1,
    ST_STREAM = 2'd2
  } mabr_state_e;
endpackage

// File: rtl/mabr_addr_latch.sv
module mabr_addr_latch #(
  parameter int DQ_W = 16,
  parameter int HI_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_n,
  input  logic                 astb_n,
  input  logic [DQ_W-1:0]      bus_in,
  output logic                 cap,
  output logic [DQ_W+HI_W-1:0] addr_nxt
);
  logic            prev_q;
  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] ph_q;

  assign cap = !sel_n && !astb_n;
  // Second consecutive strobe edge: the earlier phase becomes the upper bits.
  assign addr_nxt = {(prev_q ? ph_q : hi_q), bus_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      hi_q   <= '0;
      ph_q   <= '0;
    end else begin
      prev_q <= cap;
      if (cap) begin
        ph_q <= bus_in[HI_W-1:0];
        if (prev_q) hi_q <= ph_q;
      end
    end
  end
endmodule

// File: rtl/mabr_burst_ctrl.sv
module mabr_burst_ctrl
  import mabr_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int HI_W      = 4,
  parameter int LAT_W     = 3,
  parameter int LINE_BITS = 4,
  parameter int MEM_HI    = 2,
  parameter int MEM_LO    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel_n,
  input  logic                     cap,
  input  logic [DQ_W+HI_W-1:0]     start_addr,
  input  logic [LAT_W-1:0]         cfg_lat,
  input  logic                     cfg_linear,
  output logic                     drive_now,
  output logic                     drive_ahead,
  output logic                     busy_nxt,
  output logic                     stream_nxt,
  output logic [MEM_HI+MEM_LO-1:0] rd_idx
);
  localparam int AW = DQ_W + HI_W;

  mabr_state_e      st_q, st_n;
  logic [LAT_W-1:0] cnt_q, cnt_n, lat_eff;
  logic [AW-1:0]    addr_q, addr_n, addr_inc;
  logic             gap_q, gap_n, at_edge;

  always_comb begin
    lat_eff  = (cfg_lat < LAT_W'(2)) ? LAT_W'(2) : cfg_lat;
    at_edge  = &addr_q[LINE_BITS-1:0];
    addr_inc = cfg_linear ? (addr_q + 1'b1)
                          : {addr_q[AW-1:LINE_BITS], addr_q[LINE_BITS-1:0] + 1'b1};
    drive_now = !sel_n && !cap &&
                ((st_q == ST_STREAM && !gap_q) || (st_q == ST_LAT && cnt_q == lat_eff));

    st_n   = st_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    gap_n  = gap_q;
    if (sel_n) begin
      st_n  = ST_IDLE;
      gap_n = 1'b0;
    end else if (cap) begin
      st_n   = ST_LAT;
      cnt_n  = LAT_W'(1);
      addr_n = start_addr;
      gap_n  = 1'b0;
    end else if (drive_now) begin
      st_n   = ST_STREAM;
      addr_n = addr_inc;
      gap_n  = cfg_linear && at_edge;
    end else if (st_q == ST_STREAM) begin
      gap_n = 1'b0;
    end else if (st_q == ST_LAT) begin
      cnt_n = cnt_q + 1'b1;
    end

    drive_ahead = (st_n == ST_STREAM && !gap_n) || (st_n == ST_LAT && cnt_n == lat_eff);
    busy_nxt    = (st_n != ST_IDLE);
    stream_nxt  = (st_n == ST_STREAM);
    rd_idx      = {addr_q[DQ_W +: MEM_HI], addr_q[MEM_LO-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      gap_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      gap_q  <= gap_n;
    end
  end
endmodule

// File: rtl/mabr_word_array.sv
module mabr_word_array #(
  parameter int IDX_W = 8,
  parameter int DQ_W  = 16
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DQ_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DQ_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DQ_W'(i * 40503 + 4660);
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/mabr_responder.sv
module mabr_responder #(
  parameter int DQ_W      = 16,
  parameter int HI_W      = 4,
  parameter int LAT_W     = 3,
  parameter int LINE_BITS = 4,
  parameter int MEM_HI    = 2,
  parameter int MEM_LO    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             rd_n,
  input  logic             astb_n,
  input  logic [DQ_W-1:0]  bus_in,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_wait_high,
  input  logic             cfg_wait_early,
  input  logic             cfg_linear,
  output logic [DQ_W-1:0]  bus_out,
  output logic             bus_oe,
  output logic             wait_out,
  output logic             wait_oe
);
  localparam int AW    = DQ_W + HI_W;
  localparam int IDX_W = MEM_HI + MEM_LO;

  logic             cap, drive_now, drive_ahead, busy_nxt, stream_nxt, en, wait_act;
  logic [AW-1:0]    addr_nxt;
  logic [IDX_W-1:0] rd_idx;

  mabr_addr_latch #(.DQ_W(DQ_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst(rst), .sel_n(sel_n), .astb_n(astb_n),
    .bus_in(bus_in), .cap(cap), .addr_nxt(addr_nxt)
  );

  mabr_burst_ctrl #(
    .DQ_W(DQ_W), .HI_W(HI_W), .LAT_W(LAT_W), .LINE_BITS(LINE_BITS),
    .MEM_HI(MEM_HI), .MEM_LO(MEM_LO)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sel_n(sel_n), .cap(cap), .start_addr(addr_nxt),
    .cfg_lat(cfg_lat), .cfg_linear(cfg_linear), .drive_now(drive_now),
    .drive_ahead(drive_ahead), .busy_nxt(busy_nxt), .stream_nxt(stream_nxt),
    .rd_idx(rd_idx)
  );

  mabr_word_array #(.IDX_W(IDX_W), .DQ_W(DQ_W)) u_array (
    .clk(clk), .rd_en(drive_now), .rd_idx(rd_idx), .rd_data(bus_out)
  );

  assign en       = !sel_n && !rd_n;
  assign wait_act = busy_nxt && (cfg_wait_early ? !drive_ahead : !drive_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      wait_oe  <= 1'b0;
      wait_out <= 1'b0;
    end else begin
      bus_oe   <= en && stream_nxt;
      wait_oe  <= en;
      wait_out <= cfg_wait_high ? wait_act : !wait_act;
    end
  end
endmodule

// File: rtl/mabr_chk.sv
module mabr_chk (
  input logic clk,
  input logic rst,
  input logic sel_n,
  input logic rd_n,
  input logic astb_n,
  input logic bus_oe,
  input logic wait_oe
);
  // R12
  reset_clears_chk: assert property (@(posedge clk) rst |=> (!bus_oe && !wait_oe));
  // R3
  no_data_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !astb_n) |=> !bus_oe);
  // R11
  deselect_release_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (!bus_oe && !wait_oe));
  // R9
  data_needs_wait_drive_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> wait_oe);
  // R9
  rd_off_release_chk: assert property (@(posedge clk) disable iff (rst)
    rd_n |=> !wait_oe);
endmodule

bind mabr_responder mabr_chk i_mabr_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .rd_n(rd_n), .astb_n(astb_n),
  .bus_oe(bus_oe), .wait_oe(wait_oe)
);

// File: tb/test_mabr_responder.sv
`timescale 1ns/1ps
module test_mabr_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1, rd_n = 1'b1, astb_n = 1'b1;
  logic [15:0] bus_in = '0;
  logic [2:0]  cfg_lat = 3'd2;
  logic        cfg_wait_high = 1'b0, cfg_wait_early = 1'b0, cfg_linear = 1'b0;
  logic [15:0] bus_out;
  logic        bus_oe, wait_out, wait_oe;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0]  last_hi = '0;
  logic        ev [0:39];
  logic [19:0] ea [0:39];

  always #2.5 clk = ~clk;

  mabr_responder i_mabr_responder (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rd_n(rd_n), .astb_n(astb_n),
    .bus_in(bus_in), .cfg_lat(cfg_lat), .cfg_wait_high(cfg_wait_high),
    .cfg_wait_early(cfg_wait_early), .cfg_linear(cfg_linear),
    .bus_out(bus_out), .bus_oe(bus_oe), .wait_out(wait_out), .wait_oe(wait_oe)
  );

  function automatic logic [15:0] word_of(input logic [19:0] a);
    int unsigned k;
    k = {a[17:16], a[5:0]};
    return 16'(k * 40503 + 4660);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected slot sequence: valid flag and word address per cycle after edge E.
  task automatic plan(input logic [19:0] a0, input int lat, input bit lin);
    logic [19:0] a;
    bit gap;
    a = a0; gap = 1'b0;
    for (int k = 0; k < 40; k++) begin
      ea[k] = a;
      if (k < lat) ev[k] = 1'b0;
      else if (gap) begin ev[k] = 1'b0; gap = 1'b0; end
      else begin
        ev[k] = 1'b1;
        if (lin) begin gap = (a[3:0] == 4'hF); a = a + 1'b1; end
        else a = {a[19:4], a[3:0] + 4'h1};
      end
    end
  endtask

  // Called at a negedge; returns at the negedge of cycle 0.
  task automatic issue(input bit two, input logic [3:0] hi, input logic [15:0] lo);
    astb_n = 1'b0;
    if (two) begin
      bus_in = {12'hA5C, hi};
      @(posedge clk); @(negedge clk);
      last_hi = hi;
    end
    bus_in = lo;
    @(posedge clk); @(negedge clk);
    astb_n = 1'b1;
    bus_in = 16'h0;
  endtask

  task automatic watch(input int upto, input int lat, input bit wh, input bit early,
                       input string dtag);
    logic act;
    for (int j = 0; j <= upto; j++) begin
      if (j > 0) begin @(posedge clk); @(negedge clk); end
      check("R3 R9 data drive flag", bus_oe, (j >= lat));
      check("R9 wait drive flag", wait_oe, 1);
      act = early ? !ev[j+1] : !ev[j];
      check("R7 R8 wait level", wait_out, wh ? act : !act);
      if (ev[j]) check(dtag, bus_out, word_of(ea[j]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int le;
    bit two;
    logic [3:0] hi;
    logic [15:0] lo;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check("R12 bus_oe in reset", bus_oe, 0);
    check("R12 wait_oe in reset", wait_oe, 0);
    rst = 1'b0; sel_n = 1'b0; rd_n = 1'b0;
    @(posedge clk); @(negedge clk);

    // Sweep: latency x polarity x timing x mode, alternating one/two-phase.
    // Back-to-back runs without deselect exercise the R10 abort path.
    for (int lat = 1; lat <= 7; lat++) begin
      for (int m = 0; m < 8; m++) begin
        le = (lat < 2) ? 2 : lat;
        two = ((lat + m) % 2 == 0) || (lat == 1 && m == 0);
        hi = 4'((lat * 3 + m) & 15);
        lo = 16'((lat * 16'h0150 + m * 16'h0020) | (m[0] ? 16'h000D : 16'h000C));
        cfg_lat = 3'(lat); cfg_wait_high = m[0]; cfg_wait_early = m[1]; cfg_linear = m[2];
        plan({(two ? hi : last_hi), lo}, le, m[2]);
        issue(two, hi, lo);
        watch(le + 8, le, m[0], m[1],
              $sformatf("%s R4 R10 %s word", two ? "R1" : "R2", m[2] ? "R6" : "R5"));
      end
    end

    // R6: linear crossing with carry into the upper bits
    cfg_lat = 3'd2; cfg_wait_high = 1'b1; cfg_wait_early = 1'b0; cfg_linear = 1'b1;
    plan({4'h5, 16'hFFFE}, 2, 1'b1);
    issue(1'b1, 4'h5, 16'hFFFE);
    watch(7, 2, 1'b1, 1'b0, "R6 R1 carry word");

    // R9: output-enable off mid-burst; the burst keeps running
    cfg_lat = 3'd3; cfg_wait_high = 1'b0; cfg_linear = 1'b0;
    plan({4'h2, 16'h0040}, 3, 1'b0);
    issue(1'b1, 4'h2, 16'h0040);
    watch(3, 3, 1'b0, 1'b0, "R9 R4 word");
    rd_n = 1'b1;
    for (int j = 4; j <= 5; j++) begin
      @(posedge clk); @(negedge clk);
      check("R9 bus_oe with rd off", bus_oe, 0);
      check("R9 wait_oe with rd off", wait_oe, 0);
    end
    rd_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 bus_oe restored", bus_oe, 1);
    check("R9 burst continued word", bus_out, word_of(ea[6]));

    // R11: deselect ends the burst; reselect without strobe drives nothing
    sel_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 bus_oe deselected", bus_oe, 0);
    check("R11 wait_oe deselected", wait_oe, 0);
    sel_n = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); @(negedge clk);
      check("R11 no data after reselect", bus_oe, 0);
      check("R11 wait_oe after reselect", wait_oe, 1);
      check("R11 R7 wait idle level", wait_out, 1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule